// File: doc/BRIEF.md
# Driver Fault and Sleep Supervisor

This block supervises protection and power state for a driver with several H-bridges (two by default). It takes raw detector flags (an overcurrent flag per bridge, over-temperature, gate pump supply low, supply undervoltage) and an active-low sleep request. From them it produces one global output-disable, the charge-pump enable, a latched-overcurrent indication and a five-bit fault status word. The analog detectors and the per-bridge chopping control sit outside the block.

There are two kinds of fault. Overcurrent, meaning a shorted output, is latched. It stays set after the flag drops and clears only through power-on reset or by entering sleep. Over-temperature, pump-low and undervoltage are transparent: they disable the outputs only while they last. Sleep turns the charge pump off and holds the outputs disabled. Leaving sleep turns the pump back on at once. The outputs then stay disabled for a wake-up window (default 1 ms of clock cycles) so the pump can settle.

Every asynchronous input passes through a synchronizer before use. The overcurrent flag of a bridge must be seen on consecutive synchronized samples before it latches, which rejects single-cycle glitches.

Top module: `drv_fault_supervisor`

## Requirements
- R1: While power-on reset is held and right after it is released, out_disable_o is 1, pump_en_o is 0, oc_latched_o is 0 and status_o is 5'b11000 (undervoltage lockout and sleep).
- R2: Each asynchronous input passes through SYNC_STAGES flip-flops (default 2). A transparent fault that is sampled at a clock edge first shows on the outputs after the SYNC_STAGES-th edge and not before.
- R3: Overcurrent on one bridge latches once the flag of that same bridge is seen on OC_QUAL consecutive synchronized samples (default 2). With defaults, a flag held over two edges makes oc_latched_o rise after the fourth edge. Single samples on alternating bridges do not latch.
- R4: An overcurrent flag sampled on only one edge never sets the latch.
- R5: Once set, the overcurrent latch stays set after every overcurrent flag returns low, and it holds out_disable_o high.
- R6: The overcurrent latch clears one edge after the synchronized sleep request becomes active, and it clears on power-on reset.
- R7: Over-temperature (status bit 1) and pump-low (status bit 2) drive out_disable_o high only while their synchronized flags are high. They release by themselves with no latching.
- R8: Supply undervoltage (status bit 3) drives out_disable_o high while its synchronized flag is high.
- R9: While the synchronized sleep_n_i is low, pump_en_o is 0, status bit 4 is 1 and out_disable_o is 1.
- R10: When the synchronized sleep_n_i goes high, pump_en_o rises at once. out_disable_o stays high for exactly WAKE_CYCLES further edges (CLK_KHZ*WAKE_US/1000) and then falls if no fault is active.
- R11: status_o holds latched overcurrent in bit 0, over-temperature in bit 1, pump-low in bit 2, undervoltage in bit 3 and sleep in bit 4. out_disable_o is the OR of all status bits and the wake-up window.
- R12: For any sequence of input changes, the outputs follow R2 to R11 cycle by cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| sleep_n_i | input | 1 | Active-low sleep request, asynchronous |
| oc_det_i | input | NUM_BRIDGES | Overcurrent detect flag per bridge, asynchronous |
| ot_flag_i | input | 1 | Over-temperature flag, asynchronous |
| cp_low_i | input | 1 | Gate pump supply low flag, asynchronous |
| uv_flag_i | input | 1 | Supply undervoltage flag, asynchronous |
| out_disable_o | output | 1 | Global output disable for all bridges |
| pump_en_o | output | 1 | Charge-pump enable |
| oc_latched_o | output | 1 | Latched overcurrent indication |
| status_o | output | 5 | Fault status word, layout in R11 |

## Verification
The hardest situation to reach is an overcurrent glitch right at the qualification boundary. A flag has to be caught on exactly one edge, or on two edges but split across different bridges, and the latch must stay clear. A flag caught on exactly two edges must latch. The bench drives the flags on the falling clock edge, so each level is sampled by a known number of rising edges. A constrained-random phase then holds each input pattern for one to four cycles, which produces these near-threshold runs again and again, together with sleep entries that land while a latch is set or during a wake-up window. A bench model compares every cycle.

// File: rtl/drv_sup_pkg.sv
package drv_sup_pkg;
   // status word bit positions
   localparam int ST_OC    = 0;
   localparam int ST_OT    = 1;
   localparam int ST_PUMP  = 2;
   localparam int ST_UV    = 3;
   localparam int ST_SLEEP = 4;
   localparam int ST_W     = 5;

   typedef logic [ST_W-1:0] sup_status_t;

   // fixed positions of the non-overcurrent inputs in the sync bundle,
   // placed above the per-bridge overcurrent bits
   localparam int SB_OT    = 0;
   localparam int SB_PUMP  = 1;
   localparam int SB_UV    = 2;
   localparam int SB_SLEEP = 3;
   localparam int SB_MISC  = 4;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
   parameter int                W       = 1,
   parameter int                STAGES  = 2,
   parameter logic [W-1:0]      RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  d_i,
   output logic [W-1:0]  q_o
);
   if (W < 1) begin : g_bad_w
      $error("sup_sync: W must be at least 1");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("sup_sync: STAGES must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sup_oc_latch.sv
module sup_oc_latch #(
   parameter int NUM_BRIDGES = 2,
   parameter int OC_QUAL     = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear_i,
   input  logic [NUM_BRIDGES-1:0]  oc_s_i,
   output logic                    latched_o
);
   if (OC_QUAL < 1) begin : g_bad_qual
      $error("sup_oc_latch: OC_QUAL must be at least 1");
   end

   logic [NUM_BRIDGES-1:0] hit;

   for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
      if (OC_QUAL == 1) begin : g_direct
         assign hit[b] = oc_s_i[b];
      end else begin : g_count
         localparam int QW = $clog2(OC_QUAL);
         localparam logic [QW-1:0] QMAX = QW'(OC_QUAL - 1);
         logic [QW-1:0] run;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            run <= '0;
            else if (clear_i)      run <= '0;
            else if (!oc_s_i[b])   run <= '0;
            else if (run != QMAX)  run <= run + 1'b1;
         end

         assign hit[b] = oc_s_i[b] && (run == QMAX);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       latched_o <= 1'b0;
      else if (clear_i) latched_o <= 1'b0;
      else if (|hit)    latched_o <= 1'b1;
   end
endmodule

// File: rtl/sup_wake_timer.sv
module sup_wake_timer #(
   parameter int WAKE_CYCLES = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic asleep_i,
   output logic waking_o
);
   if (WAKE_CYCLES < 0) begin : g_bad_wake
      $error("sup_wake_timer: WAKE_CYCLES must not be negative");
   end

   if (WAKE_CYCLES == 0) begin : g_none
      assign waking_o = 1'b0;
   end else begin : g_timer
      localparam int CW = $clog2(WAKE_CYCLES + 1);
      localparam logic [CW-1:0] CMAX = CW'(WAKE_CYCLES);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           cnt <= '0;
         else if (asleep_i)    cnt <= '0;
         else if (cnt != CMAX) cnt <= cnt + 1'b1;
      end

      assign waking_o = !asleep_i && (cnt != CMAX);
   end
endmodule

// File: rtl/drv_fault_supervisor.sv
module drv_fault_supervisor #(
   parameter int NUM_BRIDGES = 2,
   parameter int SYNC_STAGES = 2,
   parameter int OC_QUAL     = 2,
   parameter int CLK_KHZ     = 50000,
   parameter int WAKE_US     = 1000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sleep_n_i,
   input  logic [NUM_BRIDGES-1:0]  oc_det_i,
   input  logic                    ot_flag_i,
   input  logic                    cp_low_i,
   input  logic                    uv_flag_i,
   output logic                    out_disable_o,
   output logic                    pump_en_o,
   output logic                    oc_latched_o,
   output logic [4:0]              status_o
);
   import drv_sup_pkg::*;

   localparam int WAKE_CYCLES = (CLK_KHZ * WAKE_US) / 1000;
   localparam int BW          = NUM_BRIDGES + SB_MISC;
   // reset values: undervoltage asserted and sleep requested so the
   // drivers come out of power-on reset locked off
   localparam logic [BW-1:0] SYNC_RST =
      BW'((1 << (NUM_BRIDGES + SB_UV)));

   if (NUM_BRIDGES < 1) begin : g_bad_nb
      $error("drv_fault_supervisor: NUM_BRIDGES must be at least 1");
   end
   if (CLK_KHZ < 1 || WAKE_US < 0) begin : g_bad_time
      $error("drv_fault_supervisor: bad clock or wake-up time");
   end

   logic [BW-1:0]          raw_bus;
   logic [BW-1:0]          sync_bus;
   logic [NUM_BRIDGES-1:0] oc_s;
   logic                   ot_s;
   logic                   pump_low_s;
   logic                   uv_s;
   logic                   asleep;
   logic                   waking;
   logic                   oc_lat;
   sup_status_t            status;

   assign raw_bus = {sleep_n_i, uv_flag_i, cp_low_i, ot_flag_i, oc_det_i};

   sup_sync #(
      .W       (BW),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_bus),
      .q_o   (sync_bus)
   );

   assign oc_s       = sync_bus[NUM_BRIDGES-1:0];
   assign ot_s       = sync_bus[NUM_BRIDGES + SB_OT];
   assign pump_low_s = sync_bus[NUM_BRIDGES + SB_PUMP];
   assign uv_s       = sync_bus[NUM_BRIDGES + SB_UV];
   assign asleep     = !sync_bus[NUM_BRIDGES + SB_SLEEP];

   sup_oc_latch #(
      .NUM_BRIDGES (NUM_BRIDGES),
      .OC_QUAL     (OC_QUAL)
   ) u_oc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (asleep),
      .oc_s_i    (oc_s),
      .latched_o (oc_lat)
   );

   sup_wake_timer #(
      .WAKE_CYCLES (WAKE_CYCLES)
   ) u_wake (
      .clk      (clk),
      .rst_n    (rst_n),
      .asleep_i (asleep),
      .waking_o (waking)
   );

   always_comb begin
      status           = '0;
      status[ST_OC]    = oc_lat;
      status[ST_OT]    = ot_s;
      status[ST_PUMP]  = pump_low_s;
      status[ST_UV]    = uv_s;
      status[ST_SLEEP] = asleep;
   end

   assign status_o      = status;
   assign oc_latched_o  = oc_lat;
   assign pump_en_o     = !asleep;
   assign out_disable_o = (|status) | waking;
endmodule

// File: rtl/drv_fault_supervisor_chk.sv
module drv_fault_supervisor_chk #(
   parameter int NUM_BRIDGES = 2,
   parameter int OC_QUAL     = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    out_disable_o,
   input  logic                    pump_en_o,
   input  logic                    oc_latched_o,
   input  logic [4:0]              status_o,
   input  logic [NUM_BRIDGES-1:0]  oc_sync
);
   // R5
   oc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_latched_o && !status_o[4]) |=> oc_latched_o);

   // R6
   oc_sleep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[4] |=> !oc_latched_o);

   // R9
   pump_off_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pump_en_o |-> (out_disable_o && status_o[4]));

   // R10
   wake_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pump_en_o) |-> out_disable_o);

   // R5
   oc_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oc_latched_o |-> out_disable_o);

   if (OC_QUAL == 2) begin : g_qual2
      // R4
      oc_qualify_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(oc_latched_o) |-> ($past(|oc_sync, 1) && $past(|oc_sync, 2)));
   end
endmodule

bind drv_fault_supervisor drv_fault_supervisor_chk #(
   .NUM_BRIDGES (NUM_BRIDGES),
   .OC_QUAL     (OC_QUAL)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .out_disable_o (out_disable_o),
   .pump_en_o     (pump_en_o),
   .oc_latched_o  (oc_latched_o),
   .status_o      (status_o),
   .oc_sync       (oc_s)
);

// File: tb/tb_drv_fault_supervisor.sv
module tb_drv_fault_supervisor;
   localparam int CLK_PERIOD = 10;
   localparam int NB         = 2;
   localparam int QUAL       = 2;
   localparam int T_KHZ      = 20000;
   localparam int T_US       = 1;
   localparam int WAKE       = (T_KHZ * T_US) / 1000;   // 20 cycles

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep_n = 1'b0;
   logic [NB-1:0] oc = '0;
   logic          ot = 1'b0;
   logic          cpl = 1'b0;
   logic          uv = 1'b0;
   logic          dis;
   logic          pump;
   logic          ocl;
   logic [4:0]    st;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   drv_fault_supervisor #(
      .NUM_BRIDGES (NB),
      .SYNC_STAGES (2),
      .OC_QUAL     (QUAL),
      .CLK_KHZ     (T_KHZ),
      .WAKE_US     (T_US)
   ) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .sleep_n_i     (sleep_n),
      .oc_det_i      (oc),
      .ot_flag_i     (ot),
      .cp_low_i      (cpl),
      .uv_flag_i     (uv),
      .out_disable_o (dis),
      .pump_en_o     (pump),
      .oc_latched_o  (ocl),
      .status_o      (st)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // ---------------- bench model (R12) ----------------
   // bundle order: oc[1:0], ot, pump-low, uv, sleep_n
   logic [5:0] m_s1, m_s2;
   int         m_run [NB];
   bit         m_lat;
   int         m_wc;

   function automatic logic [4:0] m_status();
      return {!m_s2[5], m_s2[4], m_s2[3], m_s2[2], m_lat};
   endfunction

   function automatic bit m_disable();
      bit waking;
      waking = m_s2[5] && (m_wc != WAKE);
      return (|m_status()) | waking;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = 6'b010000;
         m_s2 = 6'b010000;
         for (int b = 0; b < NB; b++) m_run[b] = 0;
         m_lat = 1'b0;
         m_wc  = 0;
      end else begin
         bit asl;
         bit hit;
         asl = !m_s2[5];
         hit = 1'b0;
         for (int b = 0; b < NB; b++) begin
            if (asl || !m_s2[b]) m_run[b] = 0;
            else begin
               if (m_run[b] >= QUAL-1) hit = 1'b1;
               else m_run[b] = m_run[b] + 1;
            end
         end
         if (asl) m_lat = 1'b0;
         else if (hit) m_lat = 1'b1;
         if (asl) m_wc = 0;
         else if (m_wc < WAKE) m_wc = m_wc + 1;
         m_s2 = m_s1;
         m_s1 = {sleep_n, uv, cpl, ot, oc};
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(st == m_status(), "R12", "status_o vs model", st, m_status());
         chk(dis == m_disable(), "R12", "out_disable_o vs model", dis, m_disable());
         chk(pump == m_s2[5], "R12", "pump_en_o vs model", pump, m_s2[5]);
         chk(ocl == m_lat, "R12", "oc_latched_o vs model", ocl, m_lat);
      end
   end

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      int unsigned seed;
      seed = 32'd20240611;
      void'($urandom(seed));

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(dis == 1'b1 && pump == 1'b0, "R1", "in reset dis/pump", {dis, pump}, 2'b10);
      rst_n = 1'b1;
      chk(st == 5'b11000, "R1", "status after reset", st, 5'b11000);
      chk(ocl == 1'b0 && dis == 1'b1 && pump == 1'b0, "R1", "outputs after reset",
          {ocl, dis, pump}, 3'b010);

      // R9/R10: wake-up sequence
      sleep_n = 1'b1;
      step(1);
      chk(pump == 1'b0, "R2", "pump before second sync edge", pump, 0);
      step(1);
      chk(pump == 1'b1 && st == 5'b00000, "R10", "pump rises on wake", {pump, st}, 6'b100000);
      step(WAKE - 1);
      chk(dis == 1'b1, "R10", "disable held in wake window", dis, 1);
      step(1);
      chk(dis == 1'b0, "R10", "disable falls after wake window", dis, 0);

      // R7/R2: over-temperature is transparent
      ot = 1'b1;
      step(1);
      chk(dis == 1'b0, "R2", "ot not visible after one edge", dis, 0);
      step(1);
      chk(dis == 1'b1 && st == 5'b00010, "R7", "ot disables", {dis, st}, 6'b100010);
      ot = 1'b0;
      step(2);
      chk(dis == 1'b0 && st == 5'b00000, "R7", "ot releases", {dis, st}, 6'b000000);

      // R7: pump-low transparent
      cpl = 1'b1;
      step(2);
      chk(dis == 1'b1 && st == 5'b00100, "R7", "pump-low disables", {dis, st}, 6'b100100);
      cpl = 1'b0;
      step(2);
      chk(dis == 1'b0, "R7", "pump-low releases", dis, 0);

      // R4: single-sample glitch rejected
      oc = 2'b01;
      step(1);
      oc = 2'b00;
      step(5);
      chk(ocl == 1'b0 && dis == 1'b0, "R4", "one-sample glitch", {ocl, dis}, 2'b00);

      // R3: samples split across bridges do not latch
      oc = 2'b01;
      step(1);
      oc = 2'b10;
      step(1);
      oc = 2'b00;
      step(5);
      chk(ocl == 1'b0, "R3", "alternating bridges", ocl, 0);

      // R3: two samples on one bridge latch after the fourth edge
      oc = 2'b10;
      step(2);
      oc = 2'b00;
      step(1);
      chk(ocl == 1'b0, "R3", "latch not yet after third edge", ocl, 0);
      step(1);
      chk(ocl == 1'b1 && st == 5'b00001 && dis == 1'b1, "R3", "latched after fourth edge",
          {ocl, st, dis}, 7'b1000011);

      // R5: persists
      step(10);
      chk(ocl == 1'b1 && dis == 1'b1, "R5", "latch persists", {ocl, dis}, 2'b11);

      // R6/R9: sleep clears
      sleep_n = 1'b0;
      step(2);
      chk(pump == 1'b0 && st == 5'b10001 && dis == 1'b1, "R9", "sleep entered",
          {pump, st, dis}, 7'b0100011);
      step(1);
      chk(ocl == 1'b0 && st == 5'b10000, "R6", "sleep clears latch", {ocl, st}, 6'b010000);
      sleep_n = 1'b1;
      step(2 + WAKE);
      chk(dis == 1'b0 && ocl == 1'b0, "R10", "awake again, clear", {dis, ocl}, 2'b00);

      // R8: undervoltage
      uv = 1'b1;
      step(2);
      chk(dis == 1'b1 && st == 5'b01000, "R8", "uv disables", {dis, st}, 6'b101000);
      ot = 1'b1;
      step(2);
      chk(st == 5'b01010, "R11", "status bit layout", st, 5'b01010);
      uv = 1'b0;
      ot = 1'b0;
      step(2);
      chk(dis == 1'b0, "R8", "uv releases", dis, 0);

      // R6: power-on reset clears the latch
      oc = 2'b01;
      step(4);
      oc = 2'b00;
      step(1);
      chk(ocl == 1'b1, "R3", "latch before reset", ocl, 1);
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      chk(ocl == 1'b0 && st == 5'b11000, "R6", "reset clears latch", {ocl, st}, 6'b011000);

      // R12: constrained random
      sleep_n = 1'b1;
      for (int i = 0; i < 1500; i++) begin
         int hold;
         oc      = ($urandom % 5 == 0) ? NB'($urandom) : '0;
         ot      = ($urandom % 8 == 0);
         cpl     = ($urandom % 8 == 0);
         uv      = ($urandom % 10 == 0);
         sleep_n = ($urandom % 30 != 0);
         hold    = 1 + int'($urandom % 4);
         step(hold);
      end
      step(3);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule